// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block chooses, every clock, which of twelve request sources a small signal-processing core should service next. It returns a take strobe, the 14-bit handler address of the winning source, and the priority index of the handler that is running now. Sources are held in a fixed priority order. Each source is either level-sensitive, taken from its synchronized input, or edge-sensitive, latched into a pending bit on a rising edge. Three external lines can be switched between the two kinds.

Software controls the block through strobed write ports. These cover a mask word for the ten maskable sources, a control word for the edge/level choice and nesting, a force/clear word for latched requests, global on/off strobes, and an end-of-handler strobe. The end-of-handler strobe retires the running handler with the highest priority. Two sources bypass the mask: a restart request and a power-down request. A write to the mask stalls servicing for one cycle.

Top module: `prio_intc`

## Requirements
- R1: Out of reset take_o is 0, vec_o is 0 and lvl_o is 12 (nothing active). All maskable sources are masked, servicing is globally on, nesting is off, and all three switchable lines are level-sensitive.
- R2: Source index i (0 highest, 11 lowest) has handler address 0x0000 for i=0, 0x002C for i=1, and 4*(i-1) for i=2..11. When several sources are eligible, the lowest index is taken.
- R3: mask_wd_i bit k enables source k+2; a masked source is never taken. A write updates the mask from the next cycle.
- R4: Sources 0 (restart, level) and 1 (power-down, edge) are taken whatever the mask holds.
- R5: In the cycle after a mask write is sampled, no source is taken. The earliest take that uses the new mask appears two edges after the write edge.
- R6: ctl_wd_i bit 0 makes source 10 edge-sensitive, bit 1 source 9, and bit 2 source 2. A cleared bit makes that source level-sensitive. Sources 1 and 7 are always edge-sensitive; all others are always level-sensitive. A level source stays requestable for as long as its synchronized input is high.
- R7: Inputs pass a two-stage synchronizer. An edge source latches a pending bit on a rising edge of its synchronized input, and taking the source clears the bit. Holding the input high gives only one take.
- R8: On fc_we_i, fc_set_i sets and fc_clr_i clears pending bits of edge-sensitive sources. Both have no effect on level-sensitive sources.
- R9: gie_off_i stops all takes, power-down and restart included, from the next cycle. gie_on_i restores them. When both strobes arrive together, off wins. Pending bits are kept while servicing is off.
- R10: With nesting on (ctl_wd_i bit 3), a source is taken only if its index is below lvl_o. lvl_o always shows the lowest active index.
- R11: With nesting off, no source is taken while any handler is active.
- R12: eoi_i retires the active handler with the lowest index. After that, sources it blocked, including a level source still asserted, become eligible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 12 | Raw request lines, bit i = source index i |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wd_i | input | 10 | Mask write data, bit k enables source k+2 |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wd_i | input | 4 | Control data: bit 0 src10 edge, bit 1 src9 edge, bit 2 src2 edge, bit 3 nesting |
| fc_we_i | input | 1 | Force/clear write strobe |
| fc_set_i | input | 12 | Pending bits to force |
| fc_clr_i | input | 12 | Pending bits to clear |
| gie_on_i | input | 1 | Global servicing on strobe |
| gie_off_i | input | 1 | Global servicing off strobe |
| eoi_i | input | 1 | End-of-handler strobe |
| take_o | output | 1 | One-cycle take strobe |
| vec_o | output | 14 | Handler address of the latest take |
| lvl_o | output | 4 | Lowest active index, 12 when idle |

## Verification
Three events can land in the same cycle, and each has a defined result. When an end-of-handler strobe arrives in the cycle a new take is decided, the take is judged against the active set before the pop, and then both changes apply. When a rising edge or a force meets a clear or a take of the same source, the new latch wins. When a mask write is followed by the blackout cycle, a source that was already pending must wait exactly one extra edge. Directed sequences set up each of these collisions with explicit expected addresses and levels. A cycle-level model in the bench judges long random runs in which strobes, edges and writes collide freely.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC  = 12;
    localparam int NMASK = NSRC - 2;
    localparam int VW    = 14;
    localparam int LW    = $clog2(NSRC + 1);

    // sources always edge-latched: power-down (1) and index 7
    localparam logic [NSRC-1:0] FIXED_EDGE = NSRC'(12'h082);

    typedef struct packed {
        logic nest;
        logic edge2;   // source 2
        logic edge1;   // source 9
        logic edge0;   // source 10
    } ctl_t;

    typedef struct packed {
        ctl_t            ctl;
        logic [NMASK-1:0] mask;
        logic            gie;
        logic            blk;
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] act;
        logic            take;
        logic [VW-1:0]   vec;
    } state_t;

    function automatic logic [VW-1:0] vec_of(input logic [LW-1:0] idx);
        if (idx == '0) return '0;
        if (idx == LW'(1)) return VW'(14'h002C);
        return VW'({idx, 2'b00}) - VW'(4);
    endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] stg_q [STAGES+1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s <= STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= din_i;
            for (int s = 1; s <= STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign level_o = stg_q[STAGES-1];
    assign rise_o  = stg_q[STAGES-1] & ~stg_q[STAGES];
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
    parameter int W  = 12,
    parameter int IW = $clog2(W + 1)
) (
    input  logic [W-1:0]  cand_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = IW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (cand_i[i]) idx_o = IW'(i);
        end
    end
    assign any_o = |cand_i;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NSRC-1:0]  req_i,
    input  logic             mask_we_i,
    input  logic [NMASK-1:0] mask_wd_i,
    input  logic             ctl_we_i,
    input  logic [3:0]       ctl_wd_i,
    input  logic             fc_we_i,
    input  logic [NSRC-1:0]  fc_set_i,
    input  logic [NSRC-1:0]  fc_clr_i,
    input  logic             gie_on_i,
    input  logic             gie_off_i,
    input  logic             eoi_i,
    output logic             take_o,
    output logic [VW-1:0]    vec_o,
    output logic [LW-1:0]    lvl_o
);
    state_t state_d, state_q;

    logic [NSRC-1:0] level_w, rise_w;
    logic [NSRC-1:0] edge_mode, avail, take_bit, top_bit;
    logic            win_any, act_any, allowed;
    logic [LW-1:0]   win_idx, top_idx;

    intc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (req_i),
        .level_o(level_w),
        .rise_o (rise_w)
    );

    always_comb begin
        edge_mode     = FIXED_EDGE;
        edge_mode[2]  = state_q.ctl.edge2;
        edge_mode[9]  = state_q.ctl.edge1;
        edge_mode[10] = state_q.ctl.edge0;
    end

    assign avail = ((state_q.pend & edge_mode) | (level_w & ~edge_mode))
                 & {state_q.mask, 2'b11};

    intc_pick #(.W(NSRC), .IW(LW)) u_pick_win (
        .cand_i(avail),
        .any_o (win_any),
        .idx_o (win_idx)
    );

    intc_pick #(.W(NSRC), .IW(LW)) u_pick_top (
        .cand_i(state_q.act),
        .any_o (act_any),
        .idx_o (top_idx)
    );

    always_comb begin
        allowed = win_any && state_q.gie && !state_q.blk;
        if (state_q.ctl.nest) allowed = allowed && (!act_any || (win_idx < top_idx));
        else                  allowed = allowed && !act_any;
        take_bit = allowed ? (NSRC'(1) << win_idx) : '0;
        top_bit  = act_any ? (NSRC'(1) << top_idx) : '0;
    end

    always_comb begin
        state_d = state_q;
        if (ctl_we_i)  state_d.ctl  = ctl_t'(ctl_wd_i);
        if (mask_we_i) state_d.mask = mask_wd_i;
        state_d.blk = mask_we_i;
        if (gie_off_i)     state_d.gie = 1'b0;
        else if (gie_on_i) state_d.gie = 1'b1;
        state_d.pend = ((state_q.pend & ~((fc_we_i ? fc_clr_i : '0) | take_bit))
                       | rise_w | (fc_we_i ? fc_set_i : '0)) & edge_mode;
        state_d.act  = (state_q.act & ~(eoi_i ? top_bit : '0)) | take_bit;
        state_d.take = allowed;
        if (allowed) state_d.vec = vec_of(win_idx);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q      <= '0;
            state_q.gie  <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign take_o = state_q.take;
    assign vec_o  = state_q.vec;
    assign lvl_o  = act_any ? top_idx : LW'(NSRC);
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
(
    input logic          clk_i,
    input logic          rst_ni,
    input logic          mask_we_i,
    input logic          gie_off_i,
    input logic          eoi_i,
    input logic          nest_i,
    input logic          take_o,
    input logic [VW-1:0] vec_o,
    input logic [LW-1:0] lvl_o
);
    logic [LW-1:0] vec_idx;
    always_comb begin
        if (vec_o == '0)               vec_idx = '0;
        else if (vec_o == VW'(14'h2C)) vec_idx = LW'(1);
        else                           vec_idx = LW'(vec_o[5:2]) + LW'(1);
    end

    a_r5_blackout: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_we_i |=> ##1 !take_o);

    a_r9_gie_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gie_off_i |=> ##1 !take_o);

    a_r11_serial: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o && !nest_i) |=> !take_o);

    a_r10_level_tracks_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> (lvl_o == vec_idx));

    a_r2_vec_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> (vec_o[1:0] == 2'b00 && vec_o <= VW'(14'h2C)));

    a_r10_lvl_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_o <= LW'(NSRC));

    a_r12_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_i && lvl_o != LW'(NSRC)) |=> (take_o || lvl_o > $past(lvl_o)));
endmodule

bind prio_intc intc_checker u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_we_i(mask_we_i),
    .gie_off_i(gie_off_i),
    .eoi_i    (eoi_i),
    .nest_i   (state_q.ctl.nest),
    .take_o   (take_o),
    .vec_o    (vec_o),
    .lvl_o    (lvl_o)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] req = '0;
    logic        mask_we = 1'b0, ctl_we = 1'b0, fc_we = 1'b0;
    logic [9:0]  mask_wd = '0;
    logic [3:0]  ctl_wd = '0;
    logic [11:0] fc_set = '0, fc_clr = '0;
    logic        gie_on = 1'b0, gie_off = 1'b0, eoi = 1'b0;
    logic        take_o;
    logic [13:0] vec_o;
    logic [3:0]  lvl_o;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    prio_intc u_prio_intc (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req),
        .mask_we_i(mask_we), .mask_wd_i(mask_wd),
        .ctl_we_i(ctl_we), .ctl_wd_i(ctl_wd),
        .fc_we_i(fc_we), .fc_set_i(fc_set), .fc_clr_i(fc_clr),
        .gie_on_i(gie_on), .gie_off_i(gie_off), .eoi_i(eoi),
        .take_o(take_o), .vec_o(vec_o), .lvl_o(lvl_o)
    );

    // ---------------- reference model from the requirements ----------------
    logic [11:0] s1, s2, s3, m_pend, m_act, em, av, tb, tp;
    logic [9:0]  m_mask;
    logic        m_e0, m_e1, m_e2, m_nest, m_gie, m_blk, m_take, al;
    logic [13:0] m_vec;
    int          w, t;

    function automatic int pick(input logic [11:0] v);
        for (int i = 0; i < 12; i++) if (v[i]) return i;
        return 12;
    endfunction

    function automatic logic [13:0] vecf(input int i);
        if (i == 0) return 14'h0000;
        if (i == 1) return 14'h002C;
        return 14'((i - 1) * 4);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            s1 = '0; s2 = '0; s3 = '0; m_pend = '0; m_act = '0; m_mask = '0;
            m_e0 = 0; m_e1 = 0; m_e2 = 0; m_nest = 0; m_gie = 1; m_blk = 0;
            m_take = 0; m_vec = '0;
        end else begin
            em = 12'h082; em[2] = m_e2; em[9] = m_e1; em[10] = m_e0;
            av = ((m_pend & em) | (s2 & ~em)) & {m_mask, 2'b11};
            w = pick(av); t = pick(m_act);
            al = (w < 12) && m_gie && !m_blk && (m_nest ? (w < t) : (t == 12));
            tb = al ? (12'b1 << w) : '0;
            tp = (t < 12) ? (12'b1 << t) : '0;
            m_pend = ((m_pend & ~((fc_we ? fc_clr : 12'h0) | tb)) | (s2 & ~s3)
                     | (fc_we ? fc_set : 12'h0)) & em;
            m_act = (m_act & ~(eoi ? tp : 12'h0)) | tb;
            m_take = al;
            if (al) m_vec = vecf(w);
            s3 = s2; s2 = s1; s1 = req;
            if (ctl_we) {m_nest, m_e2, m_e1, m_e0} = ctl_wd;
            if (mask_we) m_mask = mask_wd;
            m_blk = mask_we;
            if (gie_off) m_gie = 0; else if (gie_on) m_gie = 1;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(take_o == m_take, "R3 model take", take_o, m_take);
            if (m_take) chk(vec_o == m_vec, "R2 model vector", vec_o, m_vec);
            chk(lvl_o == 4'(pick(m_act)), "R10 model level", lvl_o, pick(m_act));
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mask(input logic [9:0] d);
        mask_wd = d; mask_we = 1; tick(); mask_we = 0;
    endtask

    task automatic wr_ctl(input logic [3:0] d);
        ctl_wd = d; ctl_we = 1; tick(); ctl_we = 0;
    endtask

    task automatic wr_fc(input logic [11:0] st, input logic [11:0] cl);
        fc_set = st; fc_clr = cl; fc_we = 1; tick(); fc_we = 0; fc_set = '0; fc_clr = '0;
    endtask

    task automatic pulse_eoi();
        eoi = 1; tick(); eoi = 0;
    endtask

    task automatic pulse_req(input int i);
        req[i] = 1; tick(); req[i] = 0;
    endtask

    task automatic wait_take(input logic [13:0] exp, input string tag);
        bit seen = 0;
        for (int k = 0; k < 12 && !seen; k++) begin
            tick();
            if (take_o) begin
                seen = 1;
                chk(vec_o == exp, tag, vec_o, exp);
            end
        end
        if (!seen) chk(0, tag, 0, 1);
    endtask

    task automatic quiet(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            tick();
            chk(!take_o, tag, take_o, 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        tick(3);
        rst_n = 1;
        tick();
        // R1 reset state
        chk(take_o == 0, "R1 take", take_o, 0);
        chk(vec_o == 0, "R1 vec", vec_o, 0);
        chk(lvl_o == 12, "R1 level", lvl_o, 12);

        // R3 masked timer, then unmasked
        req[11] = 1;
        quiet(8, "R3 masked");
        wr_mask(10'h3FF);
        wait_take(14'h0028, "R3 unmasked timer");
        chk(lvl_o == 11, "R11 level after take", lvl_o, 11);
        quiet(6, "R11 no take while active");
        pulse_eoi();
        wait_take(14'h0028, "R12 level source retaken");
        req[11] = 0; tick(4); pulse_eoi(); tick();
        chk(lvl_o == 12, "R12 idle after pop", lvl_o, 12);

        // R2 priority among three
        req[4] = 1; req[5] = 1; req[11] = 1;
        wait_take(14'h000C, "R2 highest of three");
        req[4] = 0; tick(4); pulse_eoi();
        wait_take(14'h0010, "R2 next in order");
        req[5] = 0; tick(4); pulse_eoi();
        wait_take(14'h0028, "R2 lowest");
        req[11] = 0; tick(4); pulse_eoi(); tick(2);

        // R4 nonmaskable sources
        wr_mask(10'h000);
        tick(2);
        pulse_req(1);
        wait_take(14'h002C, "R4 power-down under mask");
        pulse_eoi();
        req[0] = 1;
        wait_take(14'h0000, "R4 restart under mask");
        req[0] = 0; tick(4); pulse_eoi(); tick(2);

        // R5 blackout
        req[11] = 1; tick(5);
        mask_wd = 10'h3FF; mask_we = 1; tick(); mask_we = 0;
        chk(!take_o, "R5 write edge", take_o, 0);
        tick();
        chk(!take_o, "R5 blackout cycle", take_o, 0);
        tick();
        chk(take_o && vec_o == 14'h0028, "R5 take after blackout", vec_o, 14'h0028);
        req[11] = 0; tick(4); pulse_eoi(); tick(2);

        // R9 global off/on
        gie_off = 1; tick(); gie_off = 0;
        pulse_req(1);
        quiet(8, "R9 off blocks power-down");
        gie_on = 1; tick(); gie_on = 0;
        wait_take(14'h002C, "R9 pending kept and served");
        pulse_eoi();
        gie_off = 1; gie_on = 1; tick(); gie_off = 0; gie_on = 0;
        pulse_req(1);
        quiet(6, "R9 off wins over on");
        gie_on = 1; tick(); gie_on = 0;
        wait_take(14'h002C, "R9 restored");
        pulse_eoi(); tick(2);

        // R6 level IRQ on source 2, then edge mode R7
        req[2] = 1;
        wait_take(14'h0004, "R6 level source 2");
        pulse_eoi();
        wait_take(14'h0004, "R6 level source 2 retaken");
        req[2] = 0; tick(4); pulse_eoi(); tick(2);
        wr_ctl(4'b0100);
        req[2] = 1;
        wait_take(14'h0004, "R7 edge source 2");
        pulse_eoi();
        quiet(8, "R7 held high takes once");
        req[2] = 0; tick(4);

        // R8 force/clear
        gie_off = 1; tick(); gie_off = 0;
        pulse_req(7); tick(4);
        wr_fc(12'h000, 12'h080);
        gie_on = 1; tick(); gie_on = 0;
        quiet(8, "R8 cleared pending");
        wr_fc(12'h080, 12'h000);
        wait_take(14'h0018, "R8 forced source 7");
        pulse_eoi();
        wr_fc(12'h800, 12'h000);
        quiet(8, "R8 force on level source ignored");

        // R10 nesting
        wr_ctl(4'b1000);
        req[11] = 1;
        wait_take(14'h0028, "R10 first handler");
        req[3] = 1;
        wait_take(14'h0008, "R10 preempt");
        chk(lvl_o == 3, "R10 level shows preemptor", lvl_o, 3);
        req[9] = 1;
        quiet(6, "R10 lower priority waits");
        req[3] = 0; tick(4); pulse_eoi();
        wait_take(14'h0020, "R12 pop lets source 9 in");
        chk(lvl_o == 9, "R10 level after nested take", lvl_o, 9);
        req[9] = 0; req[11] = 0; tick(4);
        pulse_eoi(); pulse_eoi(); tick();
        chk(lvl_o == 12, "R12 all retired", lvl_o, 12);

        // random phase checked against model
        for (int c = 0; c < 6000; c++) begin
            int r;
            r = int'($urandom % 100);
            if (c % 4 == 0) req = 12'($urandom) & (($urandom % 8 == 0) ? 12'hFFF : 12'hFFE);
            mask_we = (r < 5);   mask_wd = 10'($urandom);
            ctl_we  = (r >= 5 && r < 8); ctl_wd = 4'($urandom);
            fc_we   = (r >= 8 && r < 13); fc_set = 12'($urandom); fc_clr = 12'($urandom);
            gie_off = (r >= 13 && r < 15);
            gie_on  = (r >= 14 && r < 20);
            eoi     = (r >= 30 && r < 60);
            tick();
        end
        mask_we = 0; ctl_we = 0; fc_we = 0; gie_on = 0; gie_off = 0; eoi = 0;
        tick(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule